// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block holds the transfer counters of a four-channel DMA controller. Each channel keeps a base and a current copy of a 16-bit memory address and a 16-bit transfer count, plus a 4-bit page value and a small mode word. Each time the transfer logic reports a finished transfer on a channel, the engine moves that channel's address one step up or down and lowers its count by one. The physical address it presents is the page value placed above the 16-bit current address.

Software loads the count with one less than the number of bytes to move. The transfer that takes the count from 0x0000 to 0xFFFF is the last one. On that transfer the engine sets the channel's terminal-count flag and gives a one-cycle end-of-process pulse. If the channel's mode has auto-initialization enabled, the current copies reload from their base copies. If it does not, the channel masks itself. Every channel also reports, for each accepted transfer, whether that transfer was a memory write, a memory read or a verify cycle. Request arbitration and bus handshakes are handled elsewhere.

Top module: `dma_addr_cnt_engine`

## Requirements
- R1: After a synchronous reset, every channel is masked. All counts, addresses and pages read zero. No terminal-count flag, end-of-process pulse, read strobe or write strobe is high.
- R2: An address load writes both the base and the current address of the selected channel, and a count load writes both the base and the current count. The new value is visible on the cycle after the load. A load of a copy takes precedence over a transfer that arrives on the same cycle.
- R3: Each transfer accepted on an unmasked channel with a nonzero count lowers that channel's count by exactly one, and the current count is always visible on the outputs.
- R4: Each accepted transfer steps the current address by +1 when the mode's decrement bit is 0 and by -1 when it is 1. The address wraps modulo 2^16.
- R5: The physical address is {page, current address}. A carry or borrow out of the top address bit never changes the page.
- R6: A transfer accepted while the count is 0 is the last one, so a loaded count of N gives N+1 transfers. On that transfer's clock edge the terminal-count flag is set, and end-of-process is high for exactly the following cycle.
- R7: With auto-initialization on (mode auto bit = 1), the last transfer reloads the current address and count from their base copies and leaves the mask clear.
- R8: With auto-initialization off, the last transfer sets the channel's mask. The count then reads 0xFFFF and the address reads its stepped value.
- R9: A transfer strobe on a masked channel changes neither its count nor its address, and raises no strobe.
- R10: Transfer kind is a 2-bit mode field. Kind 01 gives a one-cycle write strobe and kind 10 gives a one-cycle read strobe, on the cycle after the accepted transfer. Kinds 00 (verify) and 11 give neither strobe, but still step the address and count.
- R11: A terminal-count flag stays set until its clear input is pulsed, and a new terminal count on the same cycle as a clear wins. A mask set input wins over a mask clear input on the same cycle.
- R12: Channels are independent: a transfer on one channel leaves every other channel's count and address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ld_addr_i | input | NUM_CH | Per-channel address load strobe |
| ld_cnt_i | input | NUM_CH | Per-channel count load strobe |
| ld_page_i | input | NUM_CH | Per-channel page load strobe |
| ld_mode_i | input | NUM_CH | Per-channel mode load strobe |
| addr_data_i | input | ADDR_W | Address value for loads |
| cnt_data_i | input | CNT_W | Count value for loads |
| page_data_i | input | PAGE_W | Page value for loads |
| mode_kind_i | input | 2 | Transfer kind for mode loads |
| mode_auto_i | input | 1 | Auto-initialization bit for mode loads |
| mode_dec_i | input | 1 | Address decrement bit for mode loads |
| mask_set_i | input | NUM_CH | Per-channel mask set |
| mask_clr_i | input | NUM_CH | Per-channel mask clear |
| tc_clr_i | input | NUM_CH | Per-channel terminal-count flag clear |
| xfer_done_i | input | NUM_CH | Per-channel transfer-done strobe |
| phys_addr_o | output | NUM_CH*(PAGE_W+ADDR_W) | Physical address per channel |
| cur_cnt_o | output | NUM_CH*CNT_W | Current count per channel |
| mask_o | output | NUM_CH | Channel mask bits |
| tc_flag_o | output | NUM_CH | Terminal-count flags |
| eop_o | output | NUM_CH | One-cycle end-of-process pulses |
| mem_rd_o | output | NUM_CH | Memory read strobe per accepted transfer |
| mem_wr_o | output | NUM_CH | Memory write strobe per accepted transfer |

## Verification
The bench builds the engine with its default parameters: four channels, a 16-bit address and count, and a 4-bit page. These are the widths at which the page-isolation and count-rollover rules matter. Loading addresses of 0xFFFF and 0x0000 puts both the upward carry and the downward borrow out of the address one transfer away. Small loaded counts reach terminal count in a few cycles, in both the auto-reload and the self-masking mode. All four channels are in use at once, so a transfer on one can be checked against the state of the others.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

  typedef enum logic [1:0] {
    KIND_VERIFY  = 2'b00,
    KIND_MEM_WR  = 2'b01,
    KIND_MEM_RD  = 2'b10,
    KIND_INVALID = 2'b11
  } xfer_kind_e;

  typedef struct packed {
    xfer_kind_e kind;
    logic       auto_init;
    logic       addr_dec;
  } chan_mode_t;

  localparam chan_mode_t MODE_RESET = '{kind: KIND_VERIFY, auto_init: 1'b0, addr_dec: 1'b0};

endpackage

// File: rtl/dma_step_unit.sv
module dma_step_unit #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              dec_i,
  output logic [ADDR_W-1:0] addr_nxt_o,
  output logic [CNT_W-1:0]  cnt_nxt_o,
  output logic              last_o
);

  // Address wraps inside its own width; no carry leaves this unit.
  always_comb begin
    if (dec_i) addr_nxt_o = addr_i - ADDR_W'(1);
    else       addr_nxt_o = addr_i + ADDR_W'(1);
    cnt_nxt_o = cnt_i - CNT_W'(1);
    last_o    = (cnt_i == '0);
  end

endmodule

// File: rtl/dma_xfer_decode.sv
module dma_xfer_decode
  import dma_eng_pkg::*;
(
  input  xfer_kind_e kind_i,
  output logic       rd_o,
  output logic       wr_o
);

  always_comb begin
    rd_o = 1'b0;
    wr_o = 1'b0;
    unique case (kind_i)
      KIND_MEM_RD: rd_o = 1'b1;
      KIND_MEM_WR: wr_o = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_eng_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int PAGE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              ld_addr_i,
  input  logic              ld_cnt_i,
  input  logic              ld_page_i,
  input  logic              ld_mode_i,
  input  logic [ADDR_W-1:0] addr_data_i,
  input  logic [CNT_W-1:0]  cnt_data_i,
  input  logic [PAGE_W-1:0] page_data_i,
  input  chan_mode_t        mode_i,
  input  logic              mask_set_i,
  input  logic              mask_clr_i,
  input  logic              tc_clr_i,
  input  logic              xfer_done_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [CNT_W-1:0]  cur_cnt_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              mask_o,
  output logic              tc_o,
  output logic              eop_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o
);

  logic [ADDR_W-1:0] base_addr_q;
  logic [CNT_W-1:0]  base_cnt_q;
  chan_mode_t        mode_q;

  logic [ADDR_W-1:0] addr_nxt;
  logic [CNT_W-1:0]  cnt_nxt;
  logic              is_last;
  logic              kind_rd, kind_wr;
  logic              go;

  assign go = xfer_done_i & ~mask_o;

  dma_step_unit #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_step (
    .addr_i     (cur_addr_o),
    .cnt_i      (cur_cnt_o),
    .dec_i      (mode_q.addr_dec),
    .addr_nxt_o (addr_nxt),
    .cnt_nxt_o  (cnt_nxt),
    .last_o     (is_last)
  );

  dma_xfer_decode u_dec (
    .kind_i (mode_q.kind),
    .rd_o   (kind_rd),
    .wr_o   (kind_wr)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      cur_addr_o  <= '0;
      cur_cnt_o   <= '0;
      page_o      <= '0;
      mode_q      <= MODE_RESET;
      mask_o      <= 1'b1;
      tc_o        <= 1'b0;
      eop_o       <= 1'b0;
      mem_rd_o    <= 1'b0;
      mem_wr_o    <= 1'b0;
    end else begin
      eop_o    <= 1'b0;
      mem_rd_o <= 1'b0;
      mem_wr_o <= 1'b0;
      if (mask_clr_i) mask_o <= 1'b0;
      if (mask_set_i) mask_o <= 1'b1;
      if (tc_clr_i)   tc_o   <= 1'b0;
      if (ld_mode_i)  mode_q <= mode_i;
      if (ld_page_i)  page_o <= page_data_i;
      if (ld_addr_i) begin
        base_addr_q <= addr_data_i;
        cur_addr_o  <= addr_data_i;
      end
      if (ld_cnt_i) begin
        base_cnt_q <= cnt_data_i;
        cur_cnt_o  <= cnt_data_i;
      end
      if (go) begin
        mem_rd_o <= kind_rd;
        mem_wr_o <= kind_wr;
        if (!ld_addr_i)
          cur_addr_o <= (is_last && mode_q.auto_init) ? base_addr_q : addr_nxt;
        if (!ld_cnt_i)
          cur_cnt_o  <= (is_last && mode_q.auto_init) ? base_cnt_q : cnt_nxt;
        if (is_last) begin
          tc_o  <= 1'b1;
          eop_o <= 1'b1;
          if (!mode_q.auto_init) mask_o <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/dma_addr_cnt_engine.sv
module dma_addr_cnt_engine
  import dma_eng_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int PAGE_W = 4,
  localparam int PHYS_W = PAGE_W + ADDR_W
) (
  input  logic                          clk_i,
  input  logic                          rst_i,
  input  logic [NUM_CH-1:0]             ld_addr_i,
  input  logic [NUM_CH-1:0]             ld_cnt_i,
  input  logic [NUM_CH-1:0]             ld_page_i,
  input  logic [NUM_CH-1:0]             ld_mode_i,
  input  logic [ADDR_W-1:0]             addr_data_i,
  input  logic [CNT_W-1:0]              cnt_data_i,
  input  logic [PAGE_W-1:0]             page_data_i,
  input  logic [1:0]                    mode_kind_i,
  input  logic                          mode_auto_i,
  input  logic                          mode_dec_i,
  input  logic [NUM_CH-1:0]             mask_set_i,
  input  logic [NUM_CH-1:0]             mask_clr_i,
  input  logic [NUM_CH-1:0]             tc_clr_i,
  input  logic [NUM_CH-1:0]             xfer_done_i,
  output logic [NUM_CH-1:0][PHYS_W-1:0] phys_addr_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]  cur_cnt_o,
  output logic [NUM_CH-1:0]             mask_o,
  output logic [NUM_CH-1:0]             tc_flag_o,
  output logic [NUM_CH-1:0]             eop_o,
  output logic [NUM_CH-1:0]             mem_rd_o,
  output logic [NUM_CH-1:0]             mem_wr_o
);

  chan_mode_t mode_word;

  always_comb begin
    mode_word.kind      = xfer_kind_e'(mode_kind_i);
    mode_word.auto_init = mode_auto_i;
    mode_word.addr_dec  = mode_dec_i;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [ADDR_W-1:0] addr_q;
    logic [PAGE_W-1:0] page_q;

    dma_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_W(PAGE_W)) u_chan (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .ld_addr_i   (ld_addr_i[c]),
      .ld_cnt_i    (ld_cnt_i[c]),
      .ld_page_i   (ld_page_i[c]),
      .ld_mode_i   (ld_mode_i[c]),
      .addr_data_i (addr_data_i),
      .cnt_data_i  (cnt_data_i),
      .page_data_i (page_data_i),
      .mode_i      (mode_word),
      .mask_set_i  (mask_set_i[c]),
      .mask_clr_i  (mask_clr_i[c]),
      .tc_clr_i    (tc_clr_i[c]),
      .xfer_done_i (xfer_done_i[c]),
      .cur_addr_o  (addr_q),
      .cur_cnt_o   (cur_cnt_o[c]),
      .page_o      (page_q),
      .mask_o      (mask_o[c]),
      .tc_o        (tc_flag_o[c]),
      .eop_o       (eop_o[c]),
      .mem_rd_o    (mem_rd_o[c]),
      .mem_wr_o    (mem_wr_o[c])
    );

    // Page sits above the address with no carry path between them.
    assign phys_addr_o[c] = {page_q, addr_q};
  end

endmodule

// File: rtl/dma_engine_checker.sv
module dma_engine_checker #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int PAGE_W = 4,
  parameter int PHYS_W = 20
) (
  input logic                          clk,
  input logic                          rst,
  input logic [NUM_CH-1:0]             xfer_done,
  input logic [NUM_CH-1:0]             ld_addr,
  input logic [NUM_CH-1:0]             ld_cnt,
  input logic [NUM_CH-1:0]             ld_page,
  input logic [NUM_CH-1:0]             mask,
  input logic [NUM_CH-1:0]             eop,
  input logic [NUM_CH-1:0]             tc,
  input logic [NUM_CH-1:0]             rd,
  input logic [NUM_CH-1:0]             wr,
  input logic [NUM_CH-1:0][CNT_W-1:0]  cnt,
  input logic [NUM_CH-1:0][PHYS_W-1:0] phys
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R6
    a_r6_eop_with_tc: assert property (@(posedge clk) disable iff (rst)
      eop[i] |-> tc[i]);

    // R9
    a_r9_masked_hold: assert property (@(posedge clk) disable iff (rst)
      (mask[i] && xfer_done[i] && !ld_addr[i] && !ld_cnt[i] && !ld_page[i])
      |=> ($stable(cnt[i]) && $stable(phys[i])));

    // R5
    a_r5_page_fixed: assert property (@(posedge clk) disable iff (rst)
      !ld_page[i] |=> (phys[i][PHYS_W-1 -: PAGE_W] == $past(phys[i][PHYS_W-1 -: PAGE_W])));

    // R10
    a_r10_rd_wr_excl: assert property (@(posedge clk) disable iff (rst)
      $onehot0({rd[i], wr[i]}));

    // R10
    a_r10_strobe_cause: assert property (@(posedge clk) disable iff (rst)
      (rd[i] || wr[i]) |-> $past(xfer_done[i] && !mask[i]));

    // R3
    a_r3_count_step: assert property (@(posedge clk) disable iff (rst)
      (!mask[i] && xfer_done[i] && !ld_cnt[i] && (cnt[i] != '0))
      |=> (cnt[i] == $past(cnt[i]) - CNT_W'(1)));
  end

endmodule

bind dma_addr_cnt_engine dma_engine_checker #(
  .NUM_CH (NUM_CH),
  .CNT_W  (CNT_W),
  .PAGE_W (PAGE_W),
  .PHYS_W (PHYS_W)
) u_chk (
  .clk       (clk_i),
  .rst       (rst_i),
  .xfer_done (xfer_done_i),
  .ld_addr   (ld_addr_i),
  .ld_cnt    (ld_cnt_i),
  .ld_page   (ld_page_i),
  .mask      (mask_o),
  .eop       (eop_o),
  .tc        (tc_flag_o),
  .rd        (mem_rd_o),
  .wr        (mem_wr_o),
  .cnt       (cur_cnt_o),
  .phys      (phys_addr_o)
);

// File: tb/sim_dma_addr_cnt_engine.sv
module sim_dma_addr_cnt_engine;

  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [NCH-1:0] ld_addr = '0, ld_cnt = '0, ld_page = '0, ld_mode = '0;
  logic [15:0]    addr_data = '0;
  logic [15:0]    cnt_data = '0;
  logic [3:0]     page_data = '0;
  logic [1:0]     kind = '0;
  logic           auto_b = 1'b0, dec_b = 1'b0;
  logic [NCH-1:0] mset = '0, mclr = '0, tclr = '0, xdone = '0;
  logic [NCH-1:0][19:0] phys;
  logic [NCH-1:0][15:0] cnt;
  logic [NCH-1:0] mask, tc, eop, rd, wr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  dma_addr_cnt_engine u0 (
    .clk_i(clk), .rst_i(rst),
    .ld_addr_i(ld_addr), .ld_cnt_i(ld_cnt), .ld_page_i(ld_page), .ld_mode_i(ld_mode),
    .addr_data_i(addr_data), .cnt_data_i(cnt_data), .page_data_i(page_data),
    .mode_kind_i(kind), .mode_auto_i(auto_b), .mode_dec_i(dec_b),
    .mask_set_i(mset), .mask_clr_i(mclr), .tc_clr_i(tclr), .xfer_done_i(xdone),
    .phys_addr_o(phys), .cur_cnt_o(cnt), .mask_o(mask), .tc_flag_o(tc),
    .eop_o(eop), .mem_rd_o(rd), .mem_wr_o(wr)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic load(input int ch, input logic [15:0] a, input logic [15:0] c,
                      input logic [3:0] p, input logic [1:0] k, input logic au, input logic dc);
    addr_data = a; cnt_data = c; page_data = p; kind = k; auto_b = au; dec_b = dc;
    ld_addr = NCH'(1) << ch; ld_cnt = ld_addr; ld_page = ld_addr; ld_mode = ld_addr;
    tick();
    ld_addr = '0; ld_cnt = '0; ld_page = '0; ld_mode = '0;
  endtask

  task automatic unmask(input int ch);
    mclr = NCH'(1) << ch;
    tick();
    mclr = '0;
  endtask

  task automatic xfer(input int ch);
    xdone = NCH'(1) << ch;
    tick();
    xdone = '0;
  endtask

  task automatic t_reset();
    chk("R1 mask", mask, 4'hF);
    chk("R1 tc", tc, 0);
    chk("R1 eop", eop, 0);
    chk("R1 rd/wr", {rd, wr}, 0);
    for (int i = 0; i < NCH; i++) begin
      chk("R1 cnt", cnt[i], 0);
      chk("R1 phys", phys[i], 0);
    end
  endtask

  task automatic t_count_to_tc();
    load(0, 16'h1234, 16'd3, 4'h5, 2'b01, 1'b0, 1'b0);
    chk("R2 count loaded", cnt[0], 16'd3);
    unmask(0);
    chk("R11 mask cleared", mask[0], 0);
    xfer(0);
    chk("R3 count step", cnt[0], 16'd2);
    chk("R4 addr up", phys[0], 20'h51235);
    chk("R10 write strobe", wr[0], 1);
    chk("R10 no read", rd[0], 0);
    chk("R12 other channel", cnt[1], 0);
    xfer(0);
    xfer(0);
    chk("R3 count zero", cnt[0], 16'd0);
    chk("R6 no early eop", eop[0], 0);
    chk("R6 no early tc", tc[0], 0);
    xfer(0);
    chk("R6 eop on last", eop[0], 1);
    chk("R6 tc set", tc[0], 1);
    chk("R8 count rolls", cnt[0], 16'hFFFF);
    chk("R8 self mask", mask[0], 1);
    chk("R8 addr stepped", phys[0], 20'h51238);
    tick();
    chk("R6 eop single cycle", eop[0], 0);
    chk("R11 tc held", tc[0], 1);
    xfer(0);
    chk("R9 masked count", cnt[0], 16'hFFFF);
    chk("R9 masked addr", phys[0], 20'h51238);
    chk("R9 no strobe", wr[0], 0);
  endtask

  task automatic t_wrap_up();
    load(1, 16'hFFFF, 16'd1, 4'h3, 2'b10, 1'b0, 1'b0);
    unmask(1);
    xfer(1);
    chk("R5 carry kept off page", phys[1], 20'h30000);
    chk("R10 read strobe", rd[1], 1);
    chk("R10 no write", wr[1], 0);
    chk("R12 ch0 untouched", cnt[0], 16'hFFFF);
  endtask

  task automatic t_verify_down();
    load(2, 16'h0000, 16'd5, 4'h9, 2'b00, 1'b0, 1'b1);
    unmask(2);
    xfer(2);
    chk("R5 borrow kept off page", phys[2], 20'h9FFFF);
    chk("R4 addr down", phys[2][15:0], 16'hFFFF);
    chk("R10 verify count steps", cnt[2], 16'd4);
    chk("R10 verify no strobe", {rd[2], wr[2]}, 0);
  endtask

  task automatic t_invalid_kind();
    load(2, 16'h0010, 16'd2, 4'h1, 2'b11, 1'b0, 1'b0);
    unmask(2);
    xfer(2);
    chk("R10 kind 11 no strobe", {rd[2], wr[2]}, 0);
    chk("R10 kind 11 count", cnt[2], 16'd1);
    chk("R10 kind 11 addr", phys[2], 20'h10011);
  endtask

  task automatic t_auto();
    load(3, 16'h0100, 16'd1, 4'h2, 2'b01, 1'b1, 1'b1);
    unmask(3);
    xfer(3);
    chk("R4 auto ch down", phys[3], 20'h200FF);
    xfer(3);
    chk("R7 eop", eop[3], 1);
    chk("R7 reload addr", phys[3], 20'h20100);
    chk("R7 reload count", cnt[3], 16'd1);
    chk("R7 mask stays clear", mask[3], 0);
    tclr = 4'h8;
    tick();
    tclr = '0;
    chk("R11 tc cleared", tc[3], 0);
    xfer(3);
    xdone = 4'h8; tclr = 4'h8;
    tick();
    xdone = '0; tclr = '0;
    chk("R11 set beats clear", tc[3], 1);
  endtask

  task automatic t_priority();
    cnt_data = 16'h0050; ld_cnt = 4'h8; xdone = 4'h8;
    tick();
    ld_cnt = '0; xdone = '0;
    chk("R2 load over transfer", cnt[3], 16'h0050);
    cnt_data = 16'h0000; ld_cnt = 4'h8;
    tick();
    ld_cnt = '0;
    xfer(3);
    chk("R6 count 0 is last", eop[3], 1);
    chk("R2 base copy reloaded", cnt[3], 16'h0000);
    mset = 4'h2; mclr = 4'h2;
    tick();
    mset = '0; mclr = '0;
    chk("R11 set beats clear mask", mask[1], 1);
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_count_to_tc();
    t_wrap_up();
    t_verify_down();
    t_invalid_kind();
    t_auto();
    t_priority();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule